// File: doc/BRIEF.md
# Fractional/Integer Multiply-Accumulate Unit

This block is a single-cycle signed 16x16 multiplier feeding two 36-bit accumulators. Each accumulator has three fields: a 4-bit guard extension in bits 35:32, an upper word in bits 31:16 and a lower word in bits 15:0. An operation is presented on the operand, opcode and accumulator-select inputs together with a valid strobe. It takes effect on the rising clock edge that samples the strobe high, and its result is visible on the accumulator outputs right after that edge.

Fractional operations treat the operands as signed fractions. The 31-bit signed product is moved up one place so that it fills a 32-bit field whose bit 0 is zero. It is then sign-extended to 36 bits, and either replaces the selected accumulator or is added into it, with optional rounding to the upper word. The integer multiply treats the operands as signed integers. It writes only the low 16 bits of the product into the upper word and fills the extension with the sign of that word. The lower word keeps its old value. A flag reports when the true integer product does not fit in 16 signed bits.

Top module: `fimac_unit`

## Requirements
- R1: After reset both accumulators read zero and `intOvf` is low.
- R2: Opcode 3'b000 writes the selected accumulator with the signed product times two, sign-extended to 36 bits; 0x8000 times 0x8000 yields 36'h0_8000_0000.
- R3: Opcode 3'b001 adds the signed product times two, sign-extended to 36 bits, to the selected accumulator modulo 2^36.
- R4: Opcodes 3'b010 (multiply) and 3'b011 (multiply-accumulate) first form the R2 or R3 result, add 0x8000 to it and then clear bits 15:0, so an exact half rounds toward plus infinity.
- R5: Opcode 3'b100 writes bits 15:0 of the signed integer product into bits 31:16 of the selected accumulator, copies bit 31 into bits 35:32 and leaves bits 15:0 unchanged.
- R6: `intOvf` is set by an opcode 3'b100 operation whose product lies outside -32768..32767 and cleared by one whose product is inside that range; every other cycle leaves it unchanged.
- R7: Only the accumulator picked by `accSel` changes (0 selects `accFlat[35:0]`, 1 selects `accFlat[71:36]`).
- R8: When `inValid` is low, or the opcode is 3'b101..3'b111, neither accumulator nor the flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| opcode | input | 3 | Operation code |
| accSel | input | 1 | Destination accumulator |
| opA | input | 16 | First signed operand |
| opB | input | 16 | Second signed operand |
| accFlat | output | 72 | Both accumulators, accumulator 1 in the upper 36 bits |
| intOvf | output | 1 | Integer multiply overflow flag |

## Verification
The accumulators are the only state, so a wrong internal value shows up on `accFlat` in the cycle right after the operation that produced it. A wrong value that no later multiply overwrites stays visible, because the accumulate and integer operations read it back: an error in the lower word of an accumulator survives every later integer multiply. A wrong flag update also stays visible until the next integer multiply. Every operation is therefore compared at the ports in the following cycle against a 64-bit reference, across both accumulators.

// File: rtl/fimac_pkg.sv
package fimac_pkg;

  typedef enum logic [2:0] {
    OP_FMUL  = 3'd0,
    OP_FMAC  = 3'd1,
    OP_FMULR = 3'd2,
    OP_FMACR = 3'd3,
    OP_IMUL  = 3'd4
  } fimacOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // a legal operation is being executed
    logic accum;    // add into current accumulator value
    logic rnd;      // round to upper word, clear lower word
    logic intMul;   // integer placement instead of fractional
  } fimacCtrl_t;

endpackage

// File: rtl/fimac_ctrl.sv
module fimac_ctrl
  import fimac_pkg::*;
#(
  parameter int NUM_ACC = 2,
  localparam int SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               inValid,
  input  logic [2:0]         opcode,
  input  logic [SEL_W-1:0]   accSel,
  output fimacCtrl_t         ctrl,
  output logic [NUM_ACC-1:0] accWe
);

  always_comb begin
    ctrl = '0;
    if (inValid) begin
      unique case (opcode)
        OP_FMUL:  ctrl = '{wrEn: 1'b1, accum: 1'b0, rnd: 1'b0, intMul: 1'b0};
        OP_FMAC:  ctrl = '{wrEn: 1'b1, accum: 1'b1, rnd: 1'b0, intMul: 1'b0};
        OP_FMULR: ctrl = '{wrEn: 1'b1, accum: 1'b0, rnd: 1'b1, intMul: 1'b0};
        OP_FMACR: ctrl = '{wrEn: 1'b1, accum: 1'b1, rnd: 1'b1, intMul: 1'b0};
        OP_IMUL:  ctrl = '{wrEn: 1'b1, accum: 1'b0, rnd: 1'b0, intMul: 1'b1};
        default:  ctrl = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_we
    assign accWe[g] = ctrl.wrEn && (accSel == SEL_W'(g));
  end

endmodule

// File: rtl/fimac_datapath.sv
module fimac_datapath
  import fimac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int EXT_W   = 4,
  parameter int NUM_ACC = 2,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = EXT_W + PROD_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fimacCtrl_t               ctrl,
  input  logic [NUM_ACC-1:0]       accWe,
  input  logic [SEL_W-1:0]         accSel,
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  output logic [NUM_ACC*ACC_W-1:0] accFlat,
  output logic                     intOvf
);

  localparam logic [ACC_W-1:0] RND_HALF = ACC_W'(1) << (DATA_W - 1);

  logic [ACC_W-1:0]        accReg [NUM_ACC];
  logic [ACC_W-1:0]        accCur;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]        prodExt;
  logic [ACC_W-1:0]        fracVal;
  logic [ACC_W-1:0]        sumVal;
  logic [ACC_W-1:0]        roundSum;
  logic [ACC_W-1:0]        fracOut;
  logic [DATA_W-1:0]       intWord;
  logic [ACC_W-1:0]        intOut;
  logic [ACC_W-1:0]        nextVal;
  logic [PROD_W-DATA_W:0]  prodTop;
  logic                    ovfNext;

  assign accCur = accReg[accSel];

  // signed product, extended before the one-place shift so -1 x -1 keeps its sign
  assign prod    = $signed(opA) * $signed(opB);
  assign prodExt = {{EXT_W{prod[PROD_W-1]}}, prod};
  assign fracVal = prodExt << 1;

  assign sumVal   = ctrl.accum ? (accCur + fracVal) : fracVal;
  assign roundSum = sumVal + RND_HALF;
  assign fracOut  = ctrl.rnd ? {roundSum[ACC_W-1:DATA_W], {DATA_W{1'b0}}} : sumVal;

  // integer placement into the upper word
  assign intWord = prod[DATA_W-1:0];
  assign intOut  = {{EXT_W{intWord[DATA_W-1]}}, intWord, accCur[DATA_W-1:0]};

  assign prodTop = prod[PROD_W-1:DATA_W-1];
  assign ovfNext = !((&prodTop) || !(|prodTop));

  assign nextVal = ctrl.intMul ? intOut : fracOut;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         accReg[g] <= '0;
      else if (accWe[g]) accReg[g] <= nextVal;
    end
    assign accFlat[g*ACC_W +: ACC_W] = accReg[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         intOvf <= 1'b0;
    else if (ctrl.wrEn && ctrl.intMul) intOvf <= ovfNext;
  end

endmodule

// File: rtl/fimac_unit.sv
module fimac_unit
  import fimac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int EXT_W   = 4,
  parameter int NUM_ACC = 2,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int ACC_W  = EXT_W + 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [2:0]               opcode,
  input  logic [SEL_W-1:0]         accSel,
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  output logic [NUM_ACC*ACC_W-1:0] accFlat,
  output logic                     intOvf
);

  fimacCtrl_t         ctrl;
  logic [NUM_ACC-1:0] accWe;

  fimac_ctrl #(.NUM_ACC(NUM_ACC)) i_ctrl (
    .inValid (inValid),
    .opcode  (opcode),
    .accSel  (accSel),
    .ctrl    (ctrl),
    .accWe   (accWe)
  );

  fimac_datapath #(.DATA_W(DATA_W), .EXT_W(EXT_W), .NUM_ACC(NUM_ACC)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .accWe   (accWe),
    .accSel  (accSel),
    .opA     (opA),
    .opB     (opB),
    .accFlat (accFlat),
    .intOvf  (intOvf)
  );

endmodule

// File: rtl/fimac_checker.sv
module fimac_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  opcode,
  input logic        accSel,
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [71:0] accFlat,
  input logic        intOvf
);

  logic        selQ;
  logic [35:0] preSel, preOther, curSel, curOther;
  logic        isFrac, isRound, isInt, isNop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= accSel;
  end

  assign preSel   = accSel ? accFlat[71:36] : accFlat[35:0];
  assign preOther = accSel ? accFlat[35:0]  : accFlat[71:36];
  assign curSel   = selQ   ? accFlat[71:36] : accFlat[35:0];
  assign curOther = selQ   ? accFlat[35:0]  : accFlat[71:36];

  assign isFrac  = inValid && (opcode <= 3'd3);
  assign isRound = inValid && ((opcode == 3'd2) || (opcode == 3'd3));
  assign isInt   = inValid && (opcode == 3'd4);
  assign isNop   = !inValid || (opcode > 3'd4);

  p_frac_lsb_r2: assert property (@(posedge clk) disable iff (!rstN)
    isFrac |=> (curSel[0] == 1'b0));

  p_round_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    isRound |=> (curSel[15:0] == 16'h0000));

  p_int_lower_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    isInt |=> (curSel[15:0] == $past(preSel[15:0])));

  p_int_ext_sign_r5: assert property (@(posedge clk) disable iff (!rstN)
    isInt |=> (curSel[35:32] == {4{curSel[31]}}));

  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !isInt |=> $stable(intOvf));

  p_other_acc_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (curOther == $past(preOther)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    isNop |=> $stable(accFlat));

endmodule

bind fimac_unit fimac_checker i_fimac_checker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opcode  (opcode),
  .accSel  (accSel),
  .opA     (opA),
  .opB     (opB),
  .accFlat (accFlat),
  .intOvf  (intOvf)
);

// File: tb/test_fimac_unit.sv
module test_fimac_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic        accSel = 1'b0;
  logic [15:0] opA = 16'h0;
  logic [15:0] opB = 16'h0;
  logic [71:0] accFlat;
  logic        intOvf;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  logic [35:0] refAcc [2];
  logic        refOvf;

  fimac_unit i_fimac_unit (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opcode  (opcode),
    .accSel  (accSel),
    .opA     (opA),
    .opB     (opB),
    .accFlat (accFlat),
    .intOvf  (intOvf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG_CYCLES && !finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic checkVal(input string req, input string what,
                          input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    checkVal(req, "acc0", accFlat[35:0],  refAcc[0]);
    checkVal(req, "acc1", accFlat[71:36], refAcc[1]);
    checkVal(req, "intOvf", {35'd0, intOvf}, {35'd0, refOvf});
  endtask

  // reference built on 64-bit signed arithmetic
  task automatic refStep(input logic [2:0] op, input logic sel,
                         input logic [15:0] a, input logic [15:0] b);
    longint p, f, base;
    logic [15:0] lo;
    p = longint'($signed(a)) * longint'($signed(b));
    if (op <= 3'd3) begin
      f = p * 2;
      base = ((op == 3'd1) || (op == 3'd3)) ? longint'($signed(refAcc[sel])) + f : f;
      if (op >= 3'd2) base = (base + 64'sd32768) & ~longint'(65535);
      refAcc[sel] = base[35:0];
    end else if (op == 3'd4) begin
      lo = p[15:0];
      refOvf = (p > 64'sd32767) || (p < -64'sd32768);
      refAcc[sel] = {{4{lo[15]}}, lo, refAcc[sel][15:0]};
    end
  endtask

  // drive one cycle of valid operation, then check after the capturing edge
  task automatic doOp(input string req, input logic vld, input logic [2:0] op,
                      input logic sel, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    inValid = vld; opcode = op; accSel = sel; opA = a; opB = b;
    if (vld) refStep(op, sel, a, b);
    @(negedge clk);
    inValid = 1'b0;
    checkAll(req);
  endtask

  task automatic testReset();
    refAcc[0] = '0; refAcc[1] = '0; refOvf = 1'b0;
    checkAll("R1");
  endtask

  task automatic testFracMul();
    doOp("R2", 1'b1, 3'd0, 1'b0, 16'h4000, 16'h2000);
    doOp("R2", 1'b1, 3'd0, 1'b1, 16'hC000, 16'h1234);
    doOp("R2 minus-one squared", 1'b1, 3'd0, 1'b0, 16'h8000, 16'h8000);
    checkVal("R2", "minus-one squared literal", accFlat[35:0], 36'h0_8000_0000);
  endtask

  task automatic testFracMac();
    doOp("R3", 1'b1, 3'd1, 1'b0, 16'h8000, 16'h8000);
    doOp("R3", 1'b1, 3'd1, 1'b0, 16'h7FFF, 16'h7FFF);
    doOp("R3", 1'b1, 3'd1, 1'b1, 16'h8001, 16'h7FFF);
    for (int i = 0; i < 6; i++)
      doOp("R3 repeated", 1'b1, 3'd1, 1'b1, 16'h8000, 16'h8000);
  endtask

  task automatic testRound();
    doOp("R4 tie positive", 1'b1, 3'd2, 1'b0, 16'h0001, 16'h4000);
    checkVal("R4", "tie up literal", accFlat[35:0], 36'h0_0001_0000);
    doOp("R4 tie negative", 1'b1, 3'd2, 1'b0, 16'hFFFF, 16'h4000);
    checkVal("R4", "negative tie literal", accFlat[35:0], 36'h0_0000_0000);
    doOp("R4 below half", 1'b1, 3'd2, 1'b1, 16'h0001, 16'h3FFF);
    doOp("R4 mac", 1'b1, 3'd1, 1'b0, 16'h1357, 16'h2468);
    doOp("R4 mac round", 1'b1, 3'd3, 1'b0, 16'h0001, 16'h4000);
  endtask

  task automatic testIntMul();
    doOp("R5 seed lower", 1'b1, 3'd0, 1'b1, 16'h0123, 16'h0457);
    doOp("R5", 1'b1, 3'd4, 1'b1, 16'hFFFD, 16'h0007);
    checkVal("R5", "lower kept", {20'd0, accFlat[51:36]}, {20'd0, refAcc[1][15:0]});
    doOp("R5 positive", 1'b1, 3'd4, 1'b0, 16'h0064, 16'h0050);
  endtask

  task automatic testOverflow();
    doOp("R6 overflow", 1'b1, 3'd4, 1'b0, 16'h0100, 16'h0100);
    checkVal("R6", "flag set", {35'd0, intOvf}, 36'd1);
    doOp("R6 held by frac", 1'b1, 3'd0, 1'b1, 16'h0100, 16'h0100);
    doOp("R6 boundary -32768", 1'b1, 3'd4, 1'b0, 16'h0080, 16'hFF00);
    checkVal("R6", "flag clear", {35'd0, intOvf}, 36'd0);
    doOp("R6 boundary 32768", 1'b1, 3'd4, 1'b1, 16'h8000, 16'hFFFF);
    doOp("R6 in range", 1'b1, 3'd4, 1'b1, 16'h7FFF, 16'h0001);
  endtask

  task automatic testSelectAndIdle();
    doOp("R7 acc0 only", 1'b1, 3'd2, 1'b0, 16'h5555, 16'h3333);
    doOp("R7 acc1 only", 1'b1, 3'd1, 1'b1, 16'hAAAA, 16'h3333);
    doOp("R8 valid low", 1'b0, 3'd0, 1'b0, 16'h7FFF, 16'h7FFF);
    doOp("R6 seed", 1'b1, 3'd4, 1'b0, 16'h4000, 16'h4000);
    for (int op = 5; op < 8; op++)
      doOp("R8 reserved opcode", 1'b1, 3'(op), 1'b0, 16'h1111, 16'h2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFracMul();
    testFracMac();
    testRound();
    testIntMul();
    testOverflow();
    testSelectAndIdle();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule